// File: doc/BRIEF.md
# Conditional Absolute Jump Sequencer

This block is the control sequencer for one conditional absolute-jump instruction on a byte-wide read-only memory port. When started from idle it fetches an opcode byte at the program counter, keeps the three-bit condition field of that byte, and tests it against four flag inputs (zero, carry, parity, sign). The read of the low target byte is issued straight after the opcode fetch, without waiting for the decision. Only a taken jump goes on to read the high byte, and it then loads the program counter with the 16-bit target.

A jump that is not taken ends after the low-byte read. The program counter is then stepped past the opcode and both operand bytes. The outcome therefore sets the cost: a taken jump spends three machine cycles and ten clock states, a skipped one spends two machine cycles and seven states. The block numbers its machine cycles and clock states on its ports, raises a read strobe in one state of each machine cycle, and flags the final state of the instruction.

Top module: `cond_jump_seq`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: `busy`, `mem_rd`, `done` and `taken` are 0, `mcycle` and `tstate` are 0, and `pc` equals the RESET_PC parameter (default 0).
- R2: With `start` high in idle, the next clock begins the opcode fetch machine cycle. It lasts 4 clock states with `mem_addr` equal to `pc`, and `mem_rd` is high in clock state 2 only. Read data is captured at the end of that state.
- R3: The condition field is opcode bits [5:3]. It is tested against the flags as follows: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set. The other opcode bits have no effect on timing, addresses or outcome.
- R4: The second machine cycle always follows the fetch. It lasts 3 clock states, reads address `pc`+1 with `mem_rd` high in state 2, and takes place whether or not the jump is taken.
- R5: A taken jump adds a third machine cycle of 3 states that reads `pc`+2. The instruction takes 10 clock states, after which `pc` is {high byte, low byte}.
- R6: A jump that is not taken has no third machine cycle and does no high-byte read. It takes 7 clock states, after which `pc` is the opcode address plus 3, modulo 2^16.
- R7: `done` is high for exactly one clock, in the last state of the last machine cycle. On the following clock `busy` is 0.
- R8: `mcycle` gives the current machine cycle number (1, 2, 3) and `tstate` the clock state within it, counted from 1. Both are 0 in idle. Operand addresses wrap modulo 2^16.
- R9: `taken` takes the decision at the end of the opcode fetch and holds it until the next instruction's fetch completes.
- R10: The flags are sampled only in the last state of the opcode fetch. A flag change after that point does not alter the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction at `pc` (used in idle only) |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_sign | input | 1 | Sign flag (1 = minus) |
| mem_rdata | input | 8 | Memory read data |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| pc | output | 16 | Program counter |
| busy | output | 1 | Instruction in progress |
| mcycle | output | 2 | Machine cycle number, 0 in idle |
| tstate | output | 3 | Clock state within machine cycle, 0 in idle |
| done | output | 1 | Final state of instruction |
| taken | output | 1 | Jump decision |

## Verification
A corrupted phase or state counter shows up as a wrong `mcycle`/`tstate` pair, a misplaced `mem_rd`, or a wrong `mem_addr` in the same clock. The bench compares all of these against its model on every clock, so the error is seen at once. A wrong condition decision or a lost operand byte is first visible as an extra or missing third machine cycle, three clocks after the fetch ends. It is then visible as a wrong `pc` on the clock after `done`. The flag-change and wrap-around runs cover decisions and addresses that only look correct when the flags are sampled at the right time and the arithmetic is done modulo 2^16.

// File: rtl/jseq_pkg.sv
package jseq_pkg;

  // Phase encoding equals the machine cycle number shown on the ports.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  // Condition test: upper two bits pick a flag, the low bit gives the level required.
  function automatic logic cond_met(input logic [2:0] ccc,
                                    input logic z, input logic cy,
                                    input logic p, input logic s);
    logic f;
    case (ccc[2:1])
      2'd0:    f = z;
      2'd1:    f = cy;
      2'd2:    f = p;
      default: f = s;
    endcase
    return f == ccc[0];
  endfunction

endpackage

// File: rtl/jseq_cond.sv
module jseq_cond
  import jseq_pkg::*;
(
  input  logic [2:0] ccc,
  input  logic       flag_zero,
  input  logic       flag_carry,
  input  logic       flag_parity,
  input  logic       flag_sign,
  output logic       met
);
  always_comb met = cond_met(ccc, flag_zero, flag_carry, flag_parity, flag_sign);
endmodule

// File: rtl/jseq_timer.sv
module jseq_timer
  import jseq_pkg::*;
#(
  parameter int FETCH_STATES = 4,
  parameter int OPND_STATES  = 3,
  parameter int TS_W         = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            take_q,
  output phase_e          phase,
  output logic [TS_W-1:0] tstate,
  output logic            cycle_end,
  output logic            fin
);
  localparam logic [TS_W-1:0] FETCH_LAST = TS_W'(FETCH_STATES);
  localparam logic [TS_W-1:0] OPND_LAST  = TS_W'(OPND_STATES);
  localparam logic [TS_W-1:0] FIRST      = TS_W'(1);

  phase_e          phase_d;
  logic [TS_W-1:0] t_d;
  logic            en;

  always_comb begin
    cycle_end = ((phase == PH_FETCH) && (tstate == FETCH_LAST)) ||
                (((phase == PH_LOW) || (phase == PH_HIGH)) && (tstate == OPND_LAST));
    fin = cycle_end && ((phase == PH_HIGH) || ((phase == PH_LOW) && !take_q));
  end

  always_comb begin
    phase_d = phase;
    t_d     = tstate;
    en      = 1'b1;
    case (phase)
      PH_IDLE: begin
        en = start;
        phase_d = PH_FETCH;
        t_d     = FIRST;
      end
      PH_FETCH: begin
        if (cycle_end) begin
          phase_d = PH_LOW;
          t_d     = FIRST;
        end else begin
          t_d = tstate + FIRST;
        end
      end
      PH_LOW: begin
        if (cycle_end) begin
          phase_d = take_q ? PH_HIGH : PH_IDLE;
          t_d     = take_q ? FIRST : '0;
        end else begin
          t_d = tstate + FIRST;
        end
      end
      default: begin
        if (cycle_end) begin
          phase_d = PH_IDLE;
          t_d     = '0;
        end else begin
          t_d = tstate + FIRST;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      tstate <= '0;
    end else if (en) begin
      phase  <= phase_d;
      tstate <= t_d;
    end
  end
endmodule

// File: rtl/jseq_datapath.sv
module jseq_datapath
  import jseq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int RESET_PC = 0,
  parameter int TS_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [TS_W-1:0]   tstate,
  input  logic              cycle_end,
  input  logic              fin,
  input  logic              met,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        ccc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] pc,
  output logic              taken
);
  localparam logic [TS_W-1:0] RD_STATE = TS_W'(2);
  localparam int              CCC_LSB  = 3;

  logic [DATA_W-1:0] lo_q, hi_q;
  logic              op_en, lo_en, hi_en, dec_en;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    mem_rd = (phase != PH_IDLE) && (tstate == RD_STATE);
    op_en  = mem_rd && (phase == PH_FETCH);
    lo_en  = mem_rd && (phase == PH_LOW);
    hi_en  = mem_rd && (phase == PH_HIGH);
    dec_en = cycle_end && (phase == PH_FETCH);
    case (phase)
      PH_LOW:  mem_addr = pc + ADDR_W'(1);
      PH_HIGH: mem_addr = pc + ADDR_W'(2);
      default: mem_addr = pc;
    endcase
    pc_d = (phase == PH_HIGH) ? {hi_q, lo_q} : pc + ADDR_W'(3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccc   <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      taken <= 1'b0;
      pc    <= ADDR_W'(RESET_PC);
    end else begin
      if (op_en)  ccc   <= mem_rdata[CCC_LSB +: 3];
      if (lo_en)  lo_q  <= mem_rdata;
      if (hi_en)  hi_q  <= mem_rdata;
      if (dec_en) taken <= met;
      if (fin)    pc    <= pc_d;
    end
  end
endmodule

// File: rtl/cond_jump_seq.sv
module cond_jump_seq
  import jseq_pkg::*;
#(
  parameter  int DATA_W       = 8,
  parameter  int RESET_PC     = 0,
  parameter  int FETCH_STATES = 4,
  parameter  int OPND_STATES  = 3,
  localparam int ADDR_W       = 2 * DATA_W,
  localparam int TS_W         = $clog2(FETCH_STATES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              flag_zero,
  input  logic              flag_carry,
  input  logic              flag_parity,
  input  logic              flag_sign,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] pc,
  output logic              busy,
  output logic [1:0]        mcycle,
  output logic [TS_W-1:0]   tstate,
  output logic              done,
  output logic              taken
);
  phase_e     phase;
  logic       cycle_end, fin, met;
  logic [2:0] ccc;

  jseq_timer #(
    .FETCH_STATES(FETCH_STATES), .OPND_STATES(OPND_STATES), .TS_W(TS_W)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .take_q(taken),
    .phase(phase), .tstate(tstate), .cycle_end(cycle_end), .fin(fin)
  );

  jseq_cond i_cond (
    .ccc(ccc), .flag_zero(flag_zero), .flag_carry(flag_carry),
    .flag_parity(flag_parity), .flag_sign(flag_sign), .met(met)
  );

  jseq_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC), .TS_W(TS_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .phase(phase), .tstate(tstate),
    .cycle_end(cycle_end), .fin(fin), .met(met), .mem_rdata(mem_rdata),
    .ccc(ccc), .mem_addr(mem_addr), .mem_rd(mem_rd), .pc(pc), .taken(taken)
  );

  always_comb begin
    busy   = (phase != PH_IDLE);
    mcycle = phase;
    done   = fin;
  end
endmodule

// File: rtl/jseq_checker.sv
module jseq_checker #(
  parameter int ADDR_W       = 16,
  parameter int TS_W         = 3,
  parameter int FETCH_STATES = 4,
  parameter int OPND_STATES  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] pc,
  input logic              busy,
  input logic [1:0]        mcycle,
  input logic [TS_W-1:0]   tstate,
  input logic              done,
  input logic              taken
);
  localparam int CNT_W     = 8;
  localparam int SKIP_LEN  = FETCH_STATES + OPND_STATES;
  localparam int TAKEN_LEN = FETCH_STATES + 2 * OPND_STATES;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + CNT_W'(1);
    else           busy_cnt <= '0;
  end

  // R2: strobe only in clock state 2
  a_r2_strobe_state: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (tstate == TS_W'(2)));

  // R2: an instruction always opens with state 1 of cycle 1
  a_r2_begin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mcycle == 2'd1 && tstate == TS_W'(1)));

  // R8: counters read zero in idle
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mcycle == 2'd0 && tstate == '0 && !mem_rd));

  // R5: third machine cycle only for taken jumps
  a_r5_third_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (mcycle == 2'd3) |-> taken);

  // R5 / R6: instruction length depends on the outcome
  a_r6_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == (taken ? CNT_W'(TAKEN_LEN - 1) : CNT_W'(SKIP_LEN - 1))));

  // R6: skipped jump steps pc past the operand (low-byte address plus 2)
  a_r6_skip_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !taken) |=> (pc == $past(mem_addr) + ADDR_W'(2)));

  // R7: done is a single pulse that ends the instruction
  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R9: decision stable after the fetch
  a_r9_taken_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mcycle >= 2'd2 && $past(mcycle) >= 2'd2) |-> $stable(taken));
endmodule

bind cond_jump_seq jseq_checker #(
  .ADDR_W(ADDR_W), .TS_W(TS_W), .FETCH_STATES(FETCH_STATES), .OPND_STATES(OPND_STATES)
) i_jseq_checker (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .pc(pc),
  .busy(busy), .mcycle(mcycle), .tstate(tstate), .done(done), .taken(taken)
);

// File: tb/test_cond_jump_seq.sv
module test_cond_jump_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fz = 1'b0, fc = 1'b0, fp = 1'b0, fs = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pc;
  logic        mem_rd, busy, done, taken;
  logic [1:0]  mcycle;
  logic [2:0]  tstate;

  logic [15:0] base = 16'h0000;
  logic [7:0]  b0 = 8'hFF, b1 = 8'hFF, b2 = 8'hFF;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] pc_model = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Three-byte program image around the current opcode address
  always_comb begin
    if (mem_addr == base)                     mem_rdata = b0;
    else if (mem_addr == base + 16'd1)        mem_rdata = b1;
    else if (mem_addr == base + 16'd2)        mem_rdata = b2;
    else                                      mem_rdata = 8'hA5;
  end

  cond_jump_seq i_cond_jump_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .flag_zero(fz), .flag_carry(fc), .flag_parity(fp), .flag_sign(fs),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .pc(pc),
    .busy(busy), .mcycle(mcycle), .tstate(tstate), .done(done), .taken(taken)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // R3 condition table, written as a plain lookup
  function automatic bit expect_cond(input logic [2:0] c, input logic [3:0] fl);
    // fl = {zero, carry, parity, sign}
    case (c)
      3'd0: return !fl[3];
      3'd1: return  fl[3];
      3'd2: return !fl[2];
      3'd3: return  fl[2];
      3'd4: return !fl[1];
      3'd5: return  fl[1];
      3'd6: return !fl[0];
      default: return fl[0];
    endcase
  endfunction

  task automatic run(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [3:0] fl, input bit flip);
    logic [15:0] q_addr[$];
    bit          q_rd[$], q_done[$];
    int          q_m[$], q_t[$];
    bit          tk;
    int          nm;
    base = pc_model; b0 = op; b1 = lo; b2 = hi;
    {fz, fc, fp, fs} = fl;
    tk = expect_cond(op[5:3], fl);
    nm = tk ? 3 : 2;
    for (int m = 1; m <= nm; m++) begin
      for (int t = 1; t <= ((m == 1) ? 4 : 3); t++) begin
        q_addr.push_back(pc_model + 16'(m - 1));
        q_rd.push_back(t == 2);
        q_m.push_back(m);
        q_t.push_back(t);
        q_done.push_back((m == nm) && (t == 3));
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; q_addr.size() > 0; i++) begin
      logic [15:0] ea; bit er, ed; int em, et;
      ea = q_addr.pop_front(); er = q_rd.pop_front(); ed = q_done.pop_front();
      em = q_m.pop_front(); et = q_t.pop_front();
      check(mem_addr == ea, "R4", "mem_addr", 32'(mem_addr), 32'(ea));
      check(mem_rd == er, "R2", "mem_rd", 32'(mem_rd), 32'(er));
      check(mcycle == 2'(em) && tstate == 3'(et), "R8", "mcycle/tstate",
            {24'd0, 2'b0, mcycle, 1'b0, tstate}, {24'd0, 2'b0, 2'(em), 1'b0, 3'(et)});
      check(done == ed, "R7", "done", 32'(done), 32'(ed));
      check(busy == 1'b1, "R2", "busy", 32'(busy), 32'd1);
      if (i >= 4) check(taken == tk, "R9", "taken", 32'(taken), 32'(tk));
      if (flip && i == 4) {fz, fc, fp, fs} = ~fl;   // R10: change after sampling
      @(negedge clk);
    end
    pc_model = tk ? {hi, lo} : pc_model + 16'd3;
    check(busy == 1'b0 && done == 1'b0, "R7", "busy/done after end",
          {30'd0, busy, done}, 32'd0);
    check(pc == pc_model, tk ? "R5" : "R6", "pc", 32'(pc), 32'(pc_model));
    check(taken == tk, flip ? "R10" : "R3", "taken held", 32'(taken), 32'(tk));
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state, held in reset
    check(busy == 0 && mem_rd == 0 && done == 0 && taken == 0, "R1", "outputs in reset",
          {28'd0, busy, mem_rd, done, taken}, 32'd0);
    check(pc == 16'h0000 && mcycle == 0 && tstate == 0, "R1", "pc/counters in reset",
          32'(pc), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && pc == 16'h0000, "R1", "idle after reset", 32'(pc), 32'd0);

    // R3 / R5 / R6: every condition code with all flags clear and all set
    for (int c = 0; c < 8; c++) begin
      run({2'b11, 3'(c), 3'b010}, 8'h30 + 8'(2 * c), 8'h20 + 8'(c), 4'b0000, 1'b0);
      run({2'b11, 3'(c), 3'b010}, 8'h51 + 8'(c), 8'h61 + 8'(c), 4'b1111, 1'b0);
    end
    // R3: mixed flag patterns
    run(8'hC2, 8'h00, 8'h10, 4'b1010, 1'b0);   // zero clear test, zero set -> skip
    run(8'hEA, 8'h44, 8'h33, 4'b0101, 1'b0);   // parity set test, parity clear -> skip
    run(8'hFA, 8'h80, 8'h70, 4'b0101, 1'b0);   // sign set -> taken
    // R3: other opcode bits ignored
    run({2'b00, 3'd3, 3'b101}, 8'h11, 8'h22, 4'b0100, 1'b0);
    run({2'b01, 3'd6, 3'b111}, 8'h99, 8'h88, 4'b0001, 1'b0);
    // R10: flags flipped after the fetch
    run(8'hCA, 8'h02, 8'h40, 4'b1000, 1'b1);
    run(8'hC2, 8'h05, 8'h41, 4'b1000, 1'b1);
    // R8 / R6: wrap-around of operand addresses and of pc
    run(8'hCA, 8'hFE, 8'hFF, 4'b1000, 1'b0);   // jump to FFFE
    run(8'hCA, 8'h00, 8'h00, 4'b0000, 1'b0);   // skip from FFFE -> 0001
    run(8'hCA, 8'hFF, 8'hFF, 4'b1000, 1'b0);   // jump to FFFF
    run(8'hDA, 8'h34, 8'h12, 4'b0100, 1'b0);   // taken from FFFF, reads 0000/0001

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule